// File: doc/BRIEF.md
# Line Driver Overcurrent Autoretry Controller

This controller owns the enable of a line driver whose current-limit comparator and thermal sensor report to it as digital flags. While software enables the driver, the controller keeps it on. When autoretry is enabled and the overload flag stays high through a programmable blanking window, the controller turns the driver off for a programmable off-time. It then turns the driver back on by itself. If the overload is still there, the same blank-then-off cycle repeats until the load recovers. With autoretry disabled, overload is ignored and the analog current limit alone protects the line.

A thermal-fault flag has priority over autoretry. It turns the driver off at once and holds it off for as long as the flag stays high. If the flag persists past the blanking window, an interrupt request is raised, and a mask bit can hide it. Both time windows are chosen by 2-bit selects that index parameter tables of clock-tick counts.

Top module: `drv_autoretry`

## Requirements
- R1: After reset, `drvEn`, `faultSts` and `irq` are 0. With `swEn` high, `drvEn` is 1 after the next clock edge.
- R2: `swEn` sampled low forces `drvEn`, `faultSts` and `irq` to 0 after that edge, whatever state the controller was in. When `swEn` returns high, the driver is on again after one edge.
- R3: With `retryEn` 0 and no thermal fault, `overCur` has no effect and `drvEn` stays 1.
- R4: With `retryEn` 1 and the driver on, if `overCur` is sampled high on B consecutive edges, `drvEn` is 0 after the B-th edge. B is `BLANK_TAB[blankSel]`, with defaults 4, 8, 16 and 32 ticks for select values 0 to 3.
- R5: If `overCur` is sampled low before B consecutive high samples, the run count restarts from zero and the driver stays on.
- R6: After an overload turn-off, the driver stays off for exactly T edges and then turns on with no software action. T is `OFF_TAB[offSel]`, with defaults 12, 24, 48 and 96 ticks for select values 0 to 3. The edge that turns the driver back on does not count toward blanking.
- R7: If the overload persists after re-enable, the driver turns off again after another B edges. The cycle repeats for as long as the overload lasts.
- R8: `faultSts` is 1 exactly while the driver is forced off by an overload off-time or by a thermal fault, and 0 otherwise. `drvEn` is never 1 while `faultSts` is 1.
- R9: `thermFlt` sampled high (with `swEn` high) gives `drvEn` 0 after that edge. The driver is on again after the first edge at which `thermFlt` is sampled low.
- R10: `irq` becomes 1 once the thermal fault has persisted B edges past the turn-off edge and `faultMask` is 0. `faultMask` gates `irq` combinationally, and `irq` clears when the thermal off state is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counted in its ticks |
| rstN | input | 1 | Asynchronous active-low reset |
| overCur | input | 1 | Current-limit comparator flag |
| thermFlt | input | 1 | Driver over-temperature flag |
| swEn | input | 1 | Software driver enable |
| retryEn | input | 1 | Autoretry enable |
| blankSel | input | 2 | Blanking time select |
| offSel | input | 2 | Off-time select |
| faultMask | input | 1 | 1 hides the thermal interrupt |
| drvEn | output | 1 | Gated driver enable |
| faultStat | output | 1 | Forced-off status (named `faultSts` in the text) |
| irq | output | 1 | Thermal fault interrupt request |

## Verification
A persistent overload is applied under two blanking and off-time selections. This shows whether the off and on edges line up with the tables and whether the retry loop repeats instead of latching. An overload broken one tick short of the blanking window separates a counter that restarts from one that accumulates. A periodic overload with a duty just above the window mixes restarts and trips. The same overload with autoretry disabled, a software disable during the off-time, and long and short thermal faults under both mask values separate the priority paths and the delayed, maskable interrupt.

// File: rtl/drv_retry_pkg.sv
package drv_retry_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_OFF, ST_THERM} retry_state_e;

  typedef struct packed {
    logic clr;
    logic inc;
  } cnt_cmd_t;
endpackage

// File: rtl/retry_dpath.sv
module retry_dpath
  import drv_retry_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [3:0][CNT_W-1:0] BLANK_TAB = {16'd32, 16'd16, 16'd8, 16'd4},
  parameter logic [3:0][CNT_W-1:0] OFF_TAB   = {16'd96, 16'd48, 16'd24, 16'd12}
) (
  input  logic       clk,
  input  logic       rstN,
  input  cnt_cmd_t   cmd,
  input  logic       offPhase,
  input  logic [1:0] blankSel,
  input  logic [1:0] offSel,
  output logic       reached
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] tickCnt;
  logic [CNT_W-1:0] limit;
  logic [EXT_W-1:0] nextCnt;

  always_comb begin
    limit   = offPhase ? OFF_TAB[offSel] : BLANK_TAB[blankSel];
    nextCnt = {1'b0, tickCnt} + EXT_W'(1);
    reached = nextCnt >= {1'b0, limit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tickCnt <= '0;
    else if (cmd.clr) tickCnt <= '0;
    else if (cmd.inc) tickCnt <= tickCnt + CNT_W'(1);
  end

  // R4
  cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |-> (tickCnt != '1));

  // R5
  cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clr, cmd.inc}));
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl
  import drv_retry_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     overCur,
  input  logic     thermFlt,
  input  logic     swEn,
  input  logic     retryEn,
  input  logic     faultMask,
  input  logic     reached,
  output cnt_cmd_t cmd,
  output logic     offPhase,
  output logic     drvEn,
  output logic     faultStat,
  output logic     irq
);
  retry_state_e state, nxt;
  logic irqQ, setIrq;

  assign offPhase = (state == ST_OFF);

  always_comb begin
    nxt    = state;
    cmd    = '0;
    setIrq = 1'b0;
    if (!swEn) begin
      nxt     = ST_IDLE;
      cmd.clr = 1'b1;
    end else if (thermFlt) begin
      if (state != ST_THERM) begin
        nxt     = ST_THERM;
        cmd.clr = 1'b1;
      end else if (reached) begin
        setIrq = 1'b1;
      end else begin
        cmd.inc = 1'b1;
      end
    end else begin
      case (state)
        ST_IDLE, ST_THERM: begin
          nxt     = ST_ON;
          cmd.clr = 1'b1;
        end
        ST_ON: begin
          if (retryEn && overCur) begin
            if (reached) begin
              nxt     = ST_OFF;
              cmd.clr = 1'b1;
            end else begin
              cmd.inc = 1'b1;
            end
          end else begin
            cmd.clr = 1'b1;
          end
        end
        ST_OFF: begin
          if (reached) begin
            nxt     = ST_ON;
            cmd.clr = 1'b1;
          end else begin
            cmd.inc = 1'b1;
          end
        end
        default: begin
          nxt     = ST_IDLE;
          cmd.clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      irqQ  <= 1'b0;
    end else begin
      state <= nxt;
      irqQ  <= (nxt == ST_THERM) && (irqQ || setIrq);
    end
  end

  assign drvEn     = (state == ST_ON);
  assign faultStat = (state == ST_OFF) || (state == ST_THERM);
  assign irq       = irqQ && !faultMask;

  // R2
  sw_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !swEn |=> (!drvEn && !faultStat && !irq));

  // R3
  no_retry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drvEn && swEn && !retryEn && !thermFlt) |=> drvEn);

  // R8
  fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultStat |-> !drvEn);

  // R9
  therm_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (swEn && thermFlt) |=> (!drvEn && faultStat));

  // R9
  therm_back_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_THERM && swEn && !thermFlt) |=> drvEn);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (faultStat && !faultMask));
endmodule

// File: rtl/drv_autoretry.sv
module drv_autoretry
  import drv_retry_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [3:0][CNT_W-1:0] BLANK_TAB = {16'd32, 16'd16, 16'd8, 16'd4},
  parameter logic [3:0][CNT_W-1:0] OFF_TAB   = {16'd96, 16'd48, 16'd24, 16'd12}
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       overCur,
  input  logic       thermFlt,
  input  logic       swEn,
  input  logic       retryEn,
  input  logic [1:0] blankSel,
  input  logic [1:0] offSel,
  input  logic       faultMask,
  output logic       drvEn,
  output logic       faultStat,
  output logic       irq
);
  cnt_cmd_t cmd;
  logic     offPhase;
  logic     reached;

  retry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .overCur   (overCur),
    .thermFlt  (thermFlt),
    .swEn      (swEn),
    .retryEn   (retryEn),
    .faultMask (faultMask),
    .reached   (reached),
    .cmd       (cmd),
    .offPhase  (offPhase),
    .drvEn     (drvEn),
    .faultStat (faultStat),
    .irq       (irq)
  );

  retry_dpath #(
    .CNT_W     (CNT_W),
    .BLANK_TAB (BLANK_TAB),
    .OFF_TAB   (OFF_TAB)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .offPhase (offPhase),
    .blankSel (blankSel),
    .offSel   (offSel),
    .reached  (reached)
  );
endmodule

// File: tb/drv_autoretry_tb.sv
module drv_autoretry_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic overCur = 1'b0, thermFlt = 1'b0, swEn = 1'b0, retryEn = 1'b0;
  logic [1:0] blankSel = 2'd0, offSel = 2'd0;
  logic faultMask = 1'b1;
  logic drvEn, faultStat, irq;

  int nChk = 0, nBad = 0;
  bit done = 1'b0;

  int blankT[4] = '{4, 8, 16, 32};
  int offT[4]   = '{12, 24, 48, 96};

  // reference model state
  bit mOn = 0, mTherm = 0;
  int mOffLeft = 0, mRun = 0, mAge = 0;

  always #2 clk = ~clk;

  drv_autoretry u_dut (
    .clk(clk), .rstN(rstN), .overCur(overCur), .thermFlt(thermFlt),
    .swEn(swEn), .retryEn(retryEn), .blankSel(blankSel), .offSel(offSel),
    .faultMask(faultMask), .drvEn(drvEn), .faultStat(faultStat), .irq(irq)
  );

  task automatic chk(string tag, logic act, logic exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mOn = 0; mTherm = 0; mOffLeft = 0; mRun = 0; mAge = 0;
    end else if (!swEn) begin
      mOn = 0; mTherm = 0; mOffLeft = 0; mRun = 0; mAge = 0;
    end else if (thermFlt) begin
      if (!mTherm) begin mTherm = 1; mAge = 0; end
      else mAge++;
      mOn = 0; mOffLeft = 0; mRun = 0;
    end else if (mTherm) begin
      mTherm = 0; mOn = 1; mRun = 0;
    end else if (mOffLeft > 0) begin
      mOffLeft--;
      if (mOffLeft == 0) mOn = 1;
    end else if (!mOn) begin
      mOn = 1; mRun = 0;
    end else if (retryEn && overCur) begin
      mRun++;
      if (mRun >= blankT[blankSel]) begin
        mOn = 0; mOffLeft = offT[offSel]; mRun = 0;
      end
    end else begin
      mRun = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R4 drvEn vs model", drvEn, mOn);
      chk("R8 faultStat vs model", faultStat, mTherm || (mOffLeft > 0));
      chk("R10 irq vs model", irq, mTherm && (mAge >= blankT[blankSel]) && !faultMask);
    end
  end

  task automatic waitE(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nChk++; nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    waitE(3);
    chk("R1 reset drvEn", drvEn, 1'b0);
    chk("R1 reset faultStat", faultStat, 1'b0);
    chk("R1 reset irq", irq, 1'b0);
    rstN = 1'b1;
    waitE(2);
    swEn = 1'b1;
    waitE(1);
    chk("R1 on after enable", drvEn, 1'b1);

    // R3: overload ignored without autoretry
    overCur = 1'b1;
    waitE(40);
    chk("R3 stays on", drvEn, 1'b1);
    chk("R3 no fault", faultStat, 1'b0);

    // R4, R6, R7 with select 1
    retryEn = 1'b1; blankSel = 2'd1; offSel = 2'd1;
    waitE(7);
    chk("R4 on before window", drvEn, 1'b1);
    waitE(1);
    chk("R4 off at window", drvEn, 1'b0);
    chk("R8 fault in off", faultStat, 1'b1);
    waitE(23);
    chk("R6 still off", drvEn, 1'b0);
    waitE(1);
    chk("R6 back on", drvEn, 1'b1);
    chk("R8 fault cleared", faultStat, 1'b0);
    waitE(7);
    chk("R7 on during reblank", drvEn, 1'b1);
    waitE(1);
    chk("R7 off again", drvEn, 1'b0);

    // R2: software disable during off-time
    swEn = 1'b0;
    waitE(1);
    chk("R2 forced idle drvEn", drvEn, 1'b0);
    chk("R2 forced idle fault", faultStat, 1'b0);
    overCur = 1'b0; swEn = 1'b1;
    waitE(1);
    chk("R2 re-enable", drvEn, 1'b1);

    // R5: broken overload
    overCur = 1'b1;
    waitE(7);
    overCur = 1'b0;
    waitE(1);
    overCur = 1'b1;
    waitE(7);
    chk("R5 restart keeps on", drvEn, 1'b1);
    overCur = 1'b0;
    waitE(2);
    chk("R5 still on", drvEn, 1'b1);

    // R9, R10: long thermal fault, masked then unmasked
    blankSel = 2'd0;
    thermFlt = 1'b1; faultMask = 1'b1;
    waitE(1);
    chk("R9 thermal off", drvEn, 1'b0);
    chk("R9 thermal fault", faultStat, 1'b1);
    chk("R10 no irq yet", irq, 1'b0);
    waitE(6);
    chk("R10 masked", irq, 1'b0);
    faultMask = 1'b0;
    #1;
    chk("R10 unmasked irq", irq, 1'b1);
    waitE(1);
    thermFlt = 1'b0;
    waitE(1);
    chk("R9 thermal recover", drvEn, 1'b1);
    chk("R10 irq cleared", irq, 1'b0);

    // R10: short thermal fault gives no irq
    thermFlt = 1'b1;
    waitE(3);
    chk("R10 short fault no irq", irq, 1'b0);
    thermFlt = 1'b0;
    waitE(1);
    chk("R9 short recover", drvEn, 1'b1);

    // R7 soak with select 3, then periodic overload with select 2
    blankSel = 2'd3; offSel = 2'd3; overCur = 1'b1;
    waitE(300);
    overCur = 1'b0; swEn = 1'b0;
    waitE(1);
    blankSel = 2'd2; offSel = 2'd2; swEn = 1'b1;
    waitE(1);
    for (int i = 0; i < 400; i++) begin
      overCur = (i % 37) < 20;
      waitE(1);
    end
    overCur = 1'b0;
    waitE(60);
    chk("R6 settled on", drvEn, 1'b1);
    finishRun();
  end
endmodule